// File: doc/BRIEF.md
# PCI Interrupt Steering Router

This block lets two shared, active-low PCI interrupt lines raise ISA-style interrupt requests. Each line has an 8-bit route register. The register either names the IRQ number that the line drives or switches steering off for that line. Only eleven IRQ numbers can be targets: 3, 4, 5, 6, 7, 9, 10, 11, 12, 14 and 15. Any other number in a route register is treated as switched off.

Both lines pass through a two-flop synchronizer clocked by the PCI clock before they reach the router. A line that is low after synchronization asserts the active-high request bit of its target. When both lines point at the same target, their requests are ORed together. The 16-bit request vector is meant to be ORed with the ordinary IRQ pins outside this block. Software also has to set the target IRQ to level-sensitive triggering, but that setting lives outside this block.

Software writes a route register through a simple write strobe with a line select. The contents of both registers are always visible on a read-back port.

Top module: `pirq_steer`

## Requirements
- R1: After reset, both route registers read 0x80 and the request vector is all zero.
- R2: When `wr_en` is high at a rising edge, all 8 bits of `wr_data` are stored into the route register picked by `wr_sel` (0 = line 0, 1 = line 1). The new value is visible on `route_rd` after that edge. The other register does not change.
- R3: Route register format: bit 7 is the off flag, and bits 3:0 hold the target IRQ number. When bit 7 is 0 and the number is legal, `irq_req[number]` is high while the synchronized line is low and low while it is high. Bits 6:4 do not affect routing.
- R4: A change on `pirq_n` reaches `irq_req` on the second rising edge after the change, and not before.
- R5: When bit 7 of a route register is 1, that line drives no request bit, whatever bits 3:0 hold.
- R6: When bits 3:0 hold 0, 1, 2, 8 or 13, that line drives no request bit.
- R7: When both lines target the same IRQ, that bit is the OR of the two lines. No other bit is set, and at most two bits of `irq_req` are ever high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pirq_n | input | 2 | Shared PCI interrupt lines, active low, level sensitive |
| wr_en | input | 1 | Route register write strobe |
| wr_sel | input | 1 | Index of the route register being written |
| wr_data | input | 8 | Route register write data |
| route_rd | output | 16 | Read-back of both route registers (line 0 in bits 7:0) |
| irq_req | output | 16 | Active-high request contribution, one bit per IRQ number |

## Verification
The assertions check several properties on every cycle:
- each synchronizer output is the line value from two edges earlier;
- a write lands in the selected register;
- a switched-off or illegal route leaves the request vector at zero;
- no more request bits are ever high than there are lines.

The mapping from each register value to a specific IRQ bit, the OR of two lines sharing one target, and the cycle in which a line change first becomes visible are shown only by the bench's sweeps. These sweeps cover every code of the number field, both states of the off flag and every pair of legal targets.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

    typedef struct packed {
        logic       off;
        logic [2:0] spare;
        logic [3:0] irq;
    } route_t;

    localparam route_t ROUTE_RESET = '{off: 1'b1, spare: 3'b000, irq: 4'h0};

endpackage

// File: rtl/pirq_sync.sv
module pirq_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_n,
    output logic [WIDTH-1:0] sync_n
);
    localparam int WARM_W = $clog2(STAGES + 1);

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;
    logic [WARM_W-1:0]            warm_d, warm_q;

    always_comb begin
        chain_d[0] = pin_n;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
        warm_d = (warm_q == WARM_W'(STAGES)) ? warm_q : warm_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
            warm_q  <= '0;
        end else begin
            chain_q <= chain_d;
            warm_q  <= warm_d;
        end
    end

    assign sync_n = chain_q[STAGES-1];

    assert_sync_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == WARM_W'(STAGES)) |-> (sync_n == $past(pin_n, STAGES)));

endmodule

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
    import pirq_pkg::*;
#(
    parameter int NUM_LINES = 2,
    parameter int SEL_W     = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [SEL_W-1:0]       wr_sel,
    input  logic [7:0]             wr_data,
    output route_t [NUM_LINES-1:0] route_q
);
    route_t [NUM_LINES-1:0] route_d;

    always_comb begin
        route_d = route_q;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (wr_en && (wr_sel == SEL_W'(i))) begin
                route_d[i] = route_t'(wr_data);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            route_q <= {NUM_LINES{ROUTE_RESET}};
        end else begin
            route_q <= route_d;
        end
    end

    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (route_q[$past(wr_sel)] == route_t'($past(wr_data))));

endmodule

// File: rtl/pirq_merge.sv
module pirq_merge
    import pirq_pkg::*;
#(
    parameter int           NUM_LINES  = 2,
    parameter int           NUM_IRQ    = 16,
    parameter logic [15:0]  LEGAL_MASK = 16'hDEF8
) (
    input  logic [NUM_LINES-1:0]   active,
    input  route_t [NUM_LINES-1:0] route,
    output logic [NUM_IRQ-1:0]     req
);
    logic [NUM_LINES-1:0][NUM_IRQ-1:0] hit;

    genvar gl;
    generate
        for (gl = 0; gl < NUM_LINES; gl++) begin : g_line
            always_comb begin
                hit[gl] = '0;
                for (int j = 0; j < NUM_IRQ; j++) begin
                    if (active[gl] && !route[gl].off &&
                        (route[gl].irq == 4'(j)) && LEGAL_MASK[j]) begin
                        hit[gl][j] = 1'b1;
                    end
                end
            end
        end
    endgenerate

    always_comb begin
        req = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            req = req | hit[i];
        end
    end

endmodule

// File: rtl/pirq_steer.sv
module pirq_steer
    import pirq_pkg::*;
#(
    parameter int          NUM_LINES  = 2,
    parameter int          NUM_IRQ    = 16,
    parameter int          SYNC_DEPTH = 2,
    parameter logic [15:0] LEGAL_MASK = 16'hDEF8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_LINES-1:0]       pirq_n,
    input  logic                       wr_en,
    input  logic [SEL_W-1:0]           wr_sel,
    input  logic [7:0]                 wr_data,
    output logic [NUM_LINES-1:0][7:0]  route_rd,
    output logic [NUM_IRQ-1:0]         irq_req
);
    localparam int SEL_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

    logic [NUM_LINES-1:0]   sync_n;
    route_t [NUM_LINES-1:0] routes;

    pirq_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_DEPTH)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_n  (pirq_n),
        .sync_n (sync_n)
    );

    pirq_route_regs #(.NUM_LINES(NUM_LINES), .SEL_W(SEL_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .route_q (routes)
    );

    pirq_merge #(.NUM_LINES(NUM_LINES), .NUM_IRQ(NUM_IRQ), .LEGAL_MASK(LEGAL_MASK)) u_merge (
        .active (~sync_n),
        .route  (routes),
        .req    (irq_req)
    );

    always_comb begin
        for (int i = 0; i < NUM_LINES; i++) begin
            route_rd[i] = routes[i];
        end
    end

    logic all_off, all_illegal;
    always_comb begin
        all_off     = 1'b1;
        all_illegal = 1'b1;
        for (int i = 0; i < NUM_LINES; i++) begin
            all_off     = all_off & routes[i].off;
            all_illegal = all_illegal & !LEGAL_MASK[routes[i].irq];
        end
    end

    assert_off_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        all_off |-> (irq_req == '0));

    assert_illegal_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        all_illegal |-> (irq_req == '0));

    assert_bit_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(irq_req) <= NUM_LINES);

endmodule

// File: tb/pirq_steer_test.sv
module pirq_steer_test;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        pirq_n = 2'b11;
    logic              wr_en = 1'b0;
    logic [0:0]        wr_sel = 1'b0;
    logic [7:0]        wr_data = 8'h00;
    logic [1:0][7:0]   route_rd;
    logic [15:0]       irq_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pirq_steer uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .pirq_n   (pirq_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .route_rd (route_rd),
        .irq_req  (irq_req)
    );

    function automatic bit legal(input logic [3:0] n);
        return (n >= 3 && n <= 7) || (n >= 9 && n <= 12) || n == 14 || n == 15;
    endfunction

    function automatic logic [15:0] expect_req(input logic [7:0] ra, input logic [7:0] rb,
                                               input logic [1:0] pins_n);
        logic [15:0] e = '0;
        if (!pins_n[0] && !ra[7] && legal(ra[3:0])) e[ra[3:0]] = 1'b1;
        if (!pins_n[1] && !rb[7] && legal(rb[3:0])) e[rb[3:0]] = 1'b1;
        return e;
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic write_route(input int line, input logic [7:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 1'(line); wr_data = val;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 route0", {8'h00, route_rd[0]}, 16'h0080);
        check("R1 route1", {8'h00, route_rd[1]}, 16'h0080);
        check("R1 req", irq_req, 16'h0000);

        // Single-line sweeps: every number code, both off-flag states
        for (int line = 0; line < 2; line++) begin
            for (int off = 0; off < 2; off++) begin
                for (int n = 0; n < 16; n++) begin
                    logic [7:0] v, ra, rb;
                    logic [1:0] pins;
                    string tag;
                    v = {1'(off), 3'(n), 4'(n)};
                    ra = (line == 0) ? v : 8'h80;
                    rb = (line == 1) ? v : 8'h80;
                    write_route(0, ra);
                    write_route(1, rb);
                    check("R2 readback", {route_rd[1], route_rd[0]}, {rb, ra});
                    tag = off ? "R5" : (legal(4'(n)) ? "R3" : "R6");
                    pins = (line == 0) ? 2'b10 : 2'b01;
                    pirq_n = pins;
                    settle();
                    check(tag, irq_req, expect_req(ra, rb, pins));
                    pirq_n = 2'b11;
                    settle();
                    check("R3 release", irq_req, 16'h0000);
                end
            end
        end

        // Write to one register leaves the other alone
        write_route(0, 8'h05);
        write_route(1, 8'h0A);
        write_route(0, 8'h8C);
        check("R2 other kept", {8'h00, route_rd[1]}, 16'h000A);

        // All pairs of legal targets, all pin combinations
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                if (legal(4'(a)) && legal(4'(b))) begin
                    write_route(0, 8'(a));
                    write_route(1, 8'(b));
                    for (int p = 0; p < 4; p++) begin
                        pirq_n = 2'(p);
                        settle();
                        check("R7 pair", irq_req, expect_req(8'(a), 8'(b), 2'(p)));
                    end
                    pirq_n = 2'b11;
                end
            end
        end

        // Latency: visible on the second rising edge after the change
        write_route(0, 8'h05);
        write_route(1, 8'h80);
        pirq_n = 2'b11;
        settle();
        @(negedge clk);
        pirq_n = 2'b10;
        @(negedge clk);
        check("R4 one edge", irq_req, 16'h0000);
        @(negedge clk);
        check("R4 two edges", irq_req, 16'h0020);
        pirq_n = 2'b11;
        @(negedge clk);
        check("R4 release one edge", irq_req, 16'h0020);
        @(negedge clk);
        check("R4 release two edges", irq_req, 16'h0000);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule